// File: doc/BRIEF.md
# Multi-Channel Scan Sequencer

This block decides which of four inductive sensing channels are measured and when. Each channel has two configuration bits: a main enable and a low-power enable. A power-mode pin chooses between full mode and low-power mode. In full mode every enabled channel is active. In low-power mode a channel is active only when both of its bits are set. Each mode has its own 2-bit scan-rate code. A divider turns a reference tick into scan ticks at the selected rate.

On each scan tick the sequencer visits the active channels in ascending index order. For each channel it raises a one-cycle start strobe together with the channel index. It then waits for a done strobe from the external measurement front end. A configuration hold bit stops new conversions. When the hold bit is released, a fresh scan starts at once. A scan tick that arrives while a sequence is still running is dropped and sets a sticky overrun flag.

The reference tick is assumed to run at the fastest scan rate, 80 samples per second. Every other rate is that rate divided by a power of two.

Top module: `scan_sequencer`

## Requirements
- R1: Channel i is active exactly when `ch_en[i]` is 1 and either `pwr_full` is 1 or `ch_lpen[i]` is 1. A set `ch_lpen[i]` with a clear `ch_en[i]` has no effect.
- R2: On a scan tick the active channels are visited in ascending index order, each exactly once. Each visit is a `meas_start` pulse exactly one cycle wide, with the channel index on `meas_ch` in the same cycle.
- R3: A `meas_done` seen while busy causes one of two things on the next clock cycle: the start of the next active channel, or, after the last channel, `busy` falling. `meas_start` is only ever high while `busy` is high.
- R4: In full mode (`pwr_full`=1) scan ticks occur every 2^`np_rate` reference ticks. Codes 0,1,2,3 give 80, 40, 20 and 10 SPS.
- R5: In low-power mode (`pwr_full`=0) scan ticks occur every 16·2^`lp_rate` reference ticks. Codes 0,1,2,3 give 5, 2.5, 1.25 and 0.625 SPS.
- R6: While `cfg_hold` is 1 no `meas_start` is issued. A channel already in flight completes, and the sequence then ends.
- R7: When `cfg_hold` returns to 0, the first `meas_start` of a new scan appears two clock cycles after the first cycle in which `cfg_hold` is low. This does not wait for the divider.
- R8: A scan tick that arrives while `busy` is 1 starts nothing and sets `overrun`. This includes a tick in the same cycle as the final `meas_done`. `overrun` stays 1 until reset.
- R9: A scan tick with no active channel leaves `meas_start`, `busy` and `overrun` at 0.
- R10: After synchronous reset, `meas_start`, `busy`, `overrun` and `meas_ch` are 0.
- R11: If the power mode changes while a channel is in flight, that channel completes. The following channels are then chosen from the new active set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle reference pulse at the fastest scan rate |
| ch_en | input | NUM_CH | Per-channel main enable |
| ch_lpen | input | NUM_CH | Per-channel low-power enable |
| pwr_full | input | 1 | 1 selects full mode, 0 selects low-power mode |
| np_rate | input | RATE_W | Full-mode scan-rate code |
| lp_rate | input | RATE_W | Low-power scan-rate code |
| cfg_hold | input | 1 | Configuration hold, stops conversions |
| meas_done | input | 1 | Front end finished the current channel |
| meas_start | output | 1 | One-cycle start strobe for the front end |
| meas_ch | output | CH_W | Channel being measured |
| busy | output | 1 | A scan sequence is in progress |
| overrun | output | 1 | Sticky flag: a scan tick was dropped |

## Verification
Two events can land in the same clock cycle: the done strobe that ends a scan and a new scan tick. The bench provokes this by hand. It places a reference pulse one cycle before the final done, so that the registered scan tick meets the done on the same edge. It then expects the sequence to end, `overrun` to be set, and no start to follow. A second collision is a mode switch or a hold request during an in-flight channel. For both, the bench compares the order of visited channels against a list computed from the new enables.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [0:0] {SQ_IDLE = 1'b0, SQ_WAIT = 1'b1} sq_state_t;
endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
  parameter int RATE_W   = 2,
  parameter int LP_SHIFT = 4,
  parameter int DIV_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              pwr_full,
  input  logic [RATE_W-1:0] np_rate,
  input  logic [RATE_W-1:0] lp_rate,
  input  logic              cfg_hold,
  output logic              scan_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             kick;
  int unsigned      sh;

  // period in reference ticks: power of two chosen by mode and code
  always_comb begin
    sh  = pwr_full ? 32'(np_rate) : 32'(lp_rate) + 32'(LP_SHIFT);
    lim = DIV_W'(1) << sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      kick      <= 1'b0;
      scan_tick <= 1'b0;
    end else begin
      scan_tick <= 1'b0;
      if (cfg_hold) begin
        cnt  <= '0;
        kick <= 1'b1;
      end else if (kick) begin
        kick      <= 1'b0;
        scan_tick <= 1'b1;
        cnt       <= '0;
      end else if (ref_tick) begin
        if (cnt >= lim - DIV_W'(1)) begin
          cnt       <= '0;
          scan_tick <= 1'b1;
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/scan_chan_pick.sv
module scan_chan_pick #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_lpen,
  input  logic              pwr_full,
  input  logic [CH_W-1:0]   cur_ch,
  output logic [NUM_CH-1:0] active,
  output logic              first_vld,
  output logic [CH_W-1:0]   first_ch,
  output logic              next_vld,
  output logic [CH_W-1:0]   next_ch
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_act
    assign active[g] = ch_en[g] & (pwr_full | ch_lpen[g]);
  end

  always_comb begin
    first_vld = 1'b0;
    first_ch  = '0;
    next_vld  = 1'b0;
    next_ch   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (active[i]) begin
        first_vld = 1'b1;
        first_ch  = CH_W'(i);
        if (i > int'(cur_ch)) begin
          next_vld = 1'b1;
          next_ch  = CH_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int NUM_CH   = 4,
  parameter int RATE_W   = 2,
  parameter int LP_SHIFT = 4,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DIV_W   = (1 << RATE_W) + LP_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_lpen,
  input  logic              pwr_full,
  input  logic [RATE_W-1:0] np_rate,
  input  logic [RATE_W-1:0] lp_rate,
  input  logic              cfg_hold,
  input  logic              meas_done,
  output logic              meas_start,
  output logic [CH_W-1:0]   meas_ch,
  output logic              busy,
  output logic              overrun
);
  import scan_seq_pkg::*;

  sq_state_t         state;
  logic              scan_tick;
  logic [NUM_CH-1:0] active;
  logic              first_vld, next_vld;
  logic [CH_W-1:0]   first_ch, next_ch;

  scan_tick_gen #(.RATE_W(RATE_W), .LP_SHIFT(LP_SHIFT), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .pwr_full(pwr_full),
    .np_rate(np_rate), .lp_rate(lp_rate), .cfg_hold(cfg_hold),
    .scan_tick(scan_tick)
  );

  scan_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .ch_en(ch_en), .ch_lpen(ch_lpen), .pwr_full(pwr_full), .cur_ch(meas_ch),
    .active(active), .first_vld(first_vld), .first_ch(first_ch),
    .next_vld(next_vld), .next_ch(next_ch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      meas_start <= 1'b0;
      meas_ch    <= '0;
      overrun    <= 1'b0;
    end else begin
      meas_start <= 1'b0;
      if (scan_tick && state != SQ_IDLE) overrun <= 1'b1;
      case (state)
        SQ_IDLE: begin
          if (scan_tick && !cfg_hold && first_vld) begin
            meas_start <= 1'b1;
            meas_ch    <= first_ch;
            state      <= SQ_WAIT;
          end
        end
        default: begin
          if (meas_done) begin
            if (!cfg_hold && next_vld) begin
              meas_start <= 1'b1;
              meas_ch    <= next_ch;
            end else begin
              state <= SQ_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign busy = (state == SQ_WAIT);
endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk #(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] ch_lpen,
  input logic              pwr_full,
  input logic              cfg_hold,
  input logic              meas_start,
  input logic [CH_W-1:0]   meas_ch,
  input logic              busy,
  input logic              overrun
);
  logic [NUM_CH-1:0] act_prev;
  always_ff @(posedge clk) act_prev <= ch_en & (pwr_full ? {NUM_CH{1'b1}} : ch_lpen);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    meas_start |=> !meas_start);                                           // R2
  AST_START_ACTIVE_CH: assert property (@(posedge clk) disable iff (rst)
    meas_start |-> act_prev[meas_ch]);                                     // R1
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    meas_start |-> busy);                                                  // R3
  AST_NO_START_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_hold) |-> !meas_start);                                      // R6
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(overrun) |-> overrun);                                           // R8
endmodule

bind scan_sequencer scan_sequencer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .ch_en(ch_en), .ch_lpen(ch_lpen), .pwr_full(pwr_full),
  .cfg_hold(cfg_hold), .meas_start(meas_start), .meas_ch(meas_ch),
  .busy(busy), .overrun(overrun)
);

// File: tb/tb_scan_sequencer.sv
`timescale 1ns/1ps
module tb_scan_sequencer;
  localparam int REF_P = 16;

  logic       clk = 0, rst = 1;
  logic       ref_a = 0, ref_m = 0, done_a = 0, done_m = 0;
  logic [3:0] ch_en = 0, ch_lpen = 0;
  logic       pwr_full = 1, cfg_hold = 0;
  logic [1:0] np_rate = 0, lp_rate = 0;
  logic       meas_start, busy, overrun;
  logic [1:0] meas_ch;
  wire        ref_tick  = ref_a | ref_m;
  wire        meas_done = done_a | done_m;

  int checks = 0, errors = 0, cyc = 0, refcnt = 0, st_total = 0;
  int done_cyc = -10, gap_err = 0, last_start_cyc = 0, fe_lat = 2;
  int log_ch [64];
  int log_ref[64];
  logic ref_en = 0, fe_auto = 1, busy_prev = 0, finished = 0;

  scan_sequencer dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .ch_en(ch_en), .ch_lpen(ch_lpen),
    .pwr_full(pwr_full), .np_rate(np_rate), .lp_rate(lp_rate), .cfg_hold(cfg_hold),
    .meas_done(meas_done), .meas_start(meas_start), .meas_ch(meas_ch),
    .busy(busy), .overrun(overrun)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    repeat (REF_P - 1) @(posedge clk);
    #1 ref_a = ref_en;
    @(posedge clk);
    #1 ref_a = 0;
  end

  always begin
    @(negedge clk);
    if (fe_auto && meas_start && !rst) begin
      repeat (fe_lat) @(posedge clk);
      #1 done_a = 1;
      @(posedge clk);
      #1 done_a = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (ref_tick) refcnt++;
      if (meas_done) done_cyc = cyc;
      if (meas_start) begin
        log_ch[st_total % 64]  = int'(meas_ch);
        log_ref[st_total % 64] = refcnt;
        last_start_cyc = cyc;
        st_total++;
        if (busy_prev && (cyc - done_cyc != 1)) gap_err++;
      end
      if (busy_prev && !busy && (cyc - done_cyc != 1)) gap_err++;
    end
    busy_prev = busy;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk); rst = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_starts(input int base, input int n);
    while (st_total < base + n) @(negedge clk);
  endtask

  // hold, apply settings, release; returns start count at release
  task automatic restart(input logic pm, input logic [3:0] en, input logic [3:0] lp,
                         output int base);
    @(negedge clk); cfg_hold = 1;
    pwr_full = pm; ch_en = en; ch_lpen = lp;
    repeat (2) @(negedge clk);
    base = st_total;
    cfg_hold = 0;
  endtask

  initial begin
    #20000000;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int base, n, k, exp_mask, expn, rel_cyc, r0;
    logic ok;
    do_reset();
    // R10 reset state
    check(meas_start == 0 && busy == 0 && overrun == 0 && meas_ch == 0, "R10 reset",
          {meas_start, busy, overrun, meas_ch}, 0);

    // R7 release-to-start latency
    fe_lat = 2;
    restart(1, 4'b0001, 4'b0000, base);
    rel_cyc = cyc;
    wait_starts(base, 1);
    check(last_start_cyc - rel_cyc == 2, "R7 release latency", last_start_cyc - rel_cyc, 2);
    wait_idle();

    // R1 R2 R9 sweep over both modes and all enable combinations
    for (int pm = 0; pm < 2; pm++)
      for (int en = 0; en < 16; en++)
        for (int lp = 0; lp < 16; lp++) begin
          restart(pm[0], en[3:0], lp[3:0], base);
          repeat (4) @(negedge clk);
          wait_idle();
          exp_mask = en & (pm != 0 ? 15 : lp);
          expn = 0; k = 0; ok = 1;
          for (int i = 0; i < 4; i++) if (exp_mask[i]) expn++;
          n = st_total - base;
          if (n != expn) ok = 0;
          else
            for (int i = 0; i < 4; i++)
              if (exp_mask[i]) begin
                if (log_ch[(base + k) % 64] != i) ok = 0;
                k++;
              end
          check(ok, "R1 R2 channel order", n, expn);
        end
    check(gap_err == 0, "R3 done-to-next timing", gap_err, 0);
    check(overrun == 0, "R9 empty set no overrun", overrun, 0);

    // R4 R5 scan periods in reference ticks
    ref_en = 1;
    for (int pm = 1; pm >= 0; pm--)
      for (int c = 0; c < 4; c++) begin
        @(negedge clk); cfg_hold = 1; np_rate = c[1:0]; lp_rate = c[1:0];
        pwr_full = pm[0]; ch_en = 4'b0001; ch_lpen = 4'b0001;
        @(negedge clk);
        while (!ref_tick) @(negedge clk);
        @(negedge clk);
        base = st_total; cfg_hold = 0;
        wait_starts(base, 1);
        r0 = log_ref[base % 64];
        wait_starts(base, 2);
        n = log_ref[(base + 1) % 64] - r0;
        if (pm != 0) check(n == (1 << c), "R4 full-mode period", n, 1 << c);
        else         check(n == (16 << c), "R5 low-power period", n, 16 << c);
      end
    ref_en = 0;
    wait_idle();
    check(overrun == 0, "R8 no overrun at normal pace", overrun, 0);

    // R11 mode switch during channel 0
    fe_lat = 6;
    restart(1, 4'b1111, 4'b0101, base);
    wait_starts(base, 1);
    @(negedge clk); pwr_full = 0;
    wait_idle();
    n = st_total - base;
    check(n == 2 && log_ch[(base + 1) % 64] == 2, "R11 mode switch reselect", n, 2);
    pwr_full = 1;

    // R6 hold during channel 1, then ticks under hold
    restart(1, 4'b1111, 4'b0000, base);
    wait_starts(base, 2);
    @(negedge clk); cfg_hold = 1;
    wait_idle();
    n = st_total - base;
    check(n == 2 && log_ch[(base + 1) % 64] == 1, "R6 in-flight completes", n, 2);
    ref_en = 1; np_rate = 0;
    base = st_total;
    repeat (60) @(negedge clk);
    check(st_total == base, "R6 no start under hold", st_total - base, 0);
    ref_en = 0;
    repeat (REF_P + 2) @(negedge clk);

    // R8 ticks while busy with slow front end
    do_reset();
    check(overrun == 0, "R10 overrun cleared", overrun, 0);
    fe_lat = 20;
    restart(1, 4'b1111, 4'b0000, base);
    ref_en = 1;
    wait_starts(base, 4);
    ref_en = 0;
    wait_idle();
    check(overrun == 1, "R8 tick while busy", overrun, 1);

    // R8 tick in the same cycle as the final done
    repeat (REF_P + 2) @(negedge clk);
    do_reset();
    fe_auto = 0;
    restart(1, 4'b0100, 4'b0000, base);
    wait_starts(base, 1);
    @(posedge clk); #1 ref_m = 1;
    @(posedge clk); #1 ref_m = 0; done_m = 1;
    @(posedge clk); #1 done_m = 0;
    @(negedge clk);
    check(overrun == 1 && busy == 0, "R8 same-cycle tick and done", {overrun, busy}, 2);
    base = st_total;
    repeat (10) @(negedge clk);
    check(st_total == base && overrun == 1, "R8 dropped tick starts nothing",
          st_total - base, 0);
    fe_auto = 1;
    finish_run();
  end
endmodule